// File: doc/BRIEF.md
# Double-Buffered Serial Waveform Plotter

This block draws an audio waveform on a raster display without a frame buffer. A host streams one 8-bit sample per screen column over an asynchronous serial line (8 data bits, no parity, one stop bit). The block receives each byte and writes it into one of two sample buffers. While that buffer fills, the display reads the other one.

The display controller presents every pixel coordinate in turn. For each pixel the block looks up the sample stored for column x in the displayed buffer. One cycle later it reports whether row y lies on the trace. Row 0 is the top of the screen, so a larger sample is drawn higher up.

The two buffers trade roles only at a start-of-frame strobe, and only once every column of the write buffer holds a new sample. A frame is therefore never drawn from a partly updated set of samples. If the write buffer is incomplete at the strobe, the previous trace is drawn again.

Top module: `wave_plotter`

## Requirements
- R1: Serial bytes are received 8N1, least significant bit first. The line is oversampled OVS times per bit, with one oversampling tick every TICK_DIV clocks. A byte whose stop bit reads high is accepted.
- R2: A falling edge starts reception only if the line is still low at the middle of the start bit. A low pulse shorter than half a bit yields no byte.
- R3: A byte whose stop bit reads low is discarded. The receiver then waits for the line to return high before it looks for a new start bit.
- R4: Accepted bytes are written to consecutive write-buffer addresses, starting at 0. The byte written to address COLS-1 marks the buffer complete, and the next address is 0 again.
- R5: Bytes accepted while the write buffer is complete and not yet swapped are dropped. They change no stored sample.
- R6: On frame_start the buffers swap roles only if the write buffer is complete. After a swap, the buffer that was just filled is displayed and the other buffer starts filling at address 0. With an incomplete buffer, the strobe changes nothing.
- R7: Until the first swap after reset, pix_on is 0 for every coordinate.
- R8: pix_on is 1 exactly when y equals ROWS-1 minus s, where s is the displayed sample for column x. The result appears one clock after x and y are presented. A sample greater than ROWS-1 lights no pixel in its column.
- R9: Columns with x >= COLS never light.
- R10: Bytes arriving between two strobes do not alter the displayed trace.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd | input | 1 | Serial receive line, idle high |
| frame_start | input | 1 | One-cycle strobe at the start of each frame |
| pix_x | input | $clog2(COLS) | Current pixel column |
| pix_y | input | $clog2(ROWS) | Current pixel row |
| pix_on | output | 1 | Pixel lies on the trace, one clock after x and y |

## Verification
The bench builds the block with COLS=6, ROWS=16, TICK_DIV=2 and OVS=16. The 3-bit column input then reaches two columns beyond the screen, and a whole frame is only 128 pixels. Every sweep covers all 8×16 coordinates, so each sample lands on its exact row and every other row is checked dark. Test samples of 16 and 200 exercise the out-of-range drop. With 32-clock bits, a short glitch, a broken stop bit, partial fills, surplus bytes and a fill that runs during a sweep all fit in a short run.

// File: rtl/wp_pkg.sv
package wp_pkg;
    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP,
        RX_WAIT_HIGH
    } rx_state_e;
endpackage

// File: rtl/wp_uart_rx.sv
module wp_uart_rx
    import wp_pkg::*;
#(
    parameter int TICK_DIV = 27,
    parameter int OVS      = 16,
    parameter int DATA_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rxd,
    output logic              byte_valid,
    output logic [DATA_W-1:0] byte_data
);
    localparam int TDW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam int OCW = $clog2(OVS);
    localparam int BCW = (DATA_W > 1) ? $clog2(DATA_W) : 1;

    typedef struct packed {
        logic [1:0]        sync;
        logic [TDW-1:0]    tdiv;
        rx_state_e         state;
        logic [OCW-1:0]    ocnt;
        logic [BCW-1:0]    bcnt;
        logic [DATA_W-1:0] shreg;
        logic              valid;
    } rx_regs_t;

    rx_regs_t r_q, r_d;
    logic     tick;
    logic     rx;

    assign rx   = r_q.sync[1];
    assign tick = (r_q.tdiv == TDW'(TICK_DIV - 1));

    always_comb begin
        r_d       = r_q;
        r_d.sync  = {r_q.sync[0], rxd};
        r_d.valid = 1'b0;
        r_d.tdiv  = tick ? '0 : r_q.tdiv + 1'b1;
        if (tick) begin
            unique case (r_q.state)
                RX_IDLE: begin
                    if (!rx) begin
                        r_d.state = RX_START;
                        r_d.ocnt  = '0;
                    end
                end
                RX_START: begin
                    if (r_q.ocnt == OCW'(OVS / 2 - 1)) begin
                        r_d.ocnt  = '0;
                        r_d.bcnt  = '0;
                        r_d.state = rx ? RX_IDLE : RX_DATA;
                    end else begin
                        r_d.ocnt = r_q.ocnt + 1'b1;
                    end
                end
                RX_DATA: begin
                    if (r_q.ocnt == OCW'(OVS - 1)) begin
                        r_d.ocnt  = '0;
                        r_d.shreg = {rx, r_q.shreg[DATA_W-1:1]};
                        if (r_q.bcnt == BCW'(DATA_W - 1)) begin
                            r_d.state = RX_STOP;
                        end else begin
                            r_d.bcnt = r_q.bcnt + 1'b1;
                        end
                    end else begin
                        r_d.ocnt = r_q.ocnt + 1'b1;
                    end
                end
                RX_STOP: begin
                    if (r_q.ocnt == OCW'(OVS - 1)) begin
                        r_d.ocnt  = '0;
                        r_d.valid = rx;
                        r_d.state = rx ? RX_IDLE : RX_WAIT_HIGH;
                    end else begin
                        r_d.ocnt = r_q.ocnt + 1'b1;
                    end
                end
                RX_WAIT_HIGH: begin
                    if (rx) begin
                        r_d.state = RX_IDLE;
                    end
                end
                default: r_d.state = RX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.sync  <= 2'b11;
            r_q.state <= RX_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign byte_valid = r_q.valid;
    assign byte_data  = r_q.shreg;
endmodule

// File: rtl/wp_bank_ctrl.sv
module wp_bank_ctrl #(
    parameter int COLS = 320,
    parameter int AW   = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          byte_valid,
    input  logic          frame_start,
    output logic          we,
    output logic [AW-1:0] wr_addr,
    output logic          wr_bank,
    output logic          rd_bank,
    output logic          full,
    output logic          disp_valid
);
    typedef struct packed {
        logic          bank;
        logic [AW-1:0] addr;
        logic          full;
        logic          shown;
    } bank_regs_t;

    bank_regs_t b_q, b_d;

    assign we = byte_valid && !b_q.full;

    always_comb begin
        b_d = b_q;
        if (we) begin
            if (b_q.addr == AW'(COLS - 1)) begin
                b_d.addr = '0;
                b_d.full = 1'b1;
            end else begin
                b_d.addr = b_q.addr + 1'b1;
            end
        end
        if (frame_start && b_q.full) begin
            b_d.bank  = ~b_q.bank;
            b_d.full  = 1'b0;
            b_d.addr  = '0;
            b_d.shown = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            b_q <= '0;
        end else begin
            b_q <= b_d;
        end
    end

    assign wr_addr    = b_q.addr;
    assign wr_bank    = b_q.bank;
    assign rd_bank    = ~b_q.bank;
    assign full       = b_q.full;
    assign disp_valid = b_q.shown;
endmodule

// File: rtl/wp_sample_ram.sv
module wp_sample_ram #(
    parameter int AW = 9,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW:0]   waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW:0]   raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 2 ** (AW + 1);

    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        rdata_q <= mem[raddr];
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/wave_plotter.sv
module wave_plotter
    import wp_pkg::*;
#(
    parameter int COLS     = 320,
    parameter int ROWS     = 240,
    parameter int TICK_DIV = 27,
    parameter int OVS      = 16,
    parameter int SAMPLE_W = 8,
    localparam int XW      = $clog2(COLS),
    localparam int YW      = $clog2(ROWS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rxd,
    input  logic          frame_start,
    input  logic [XW-1:0] pix_x,
    input  logic [YW-1:0] pix_y,
    output logic          pix_on
);
    typedef struct packed {
        logic [YW-1:0] y;
        logic          in_range;
        logic          valid;
    } pix_regs_t;

    logic                byte_valid;
    logic [SAMPLE_W-1:0] byte_data;
    logic                ram_we;
    logic [XW-1:0]       wr_addr;
    logic                wr_bank;
    logic                rd_bank;
    logic                buf_full;
    logic                disp_valid;
    logic [SAMPLE_W-1:0] sample;
    pix_regs_t           p_q, p_d;

    wp_uart_rx #(
        .TICK_DIV(TICK_DIV),
        .OVS     (OVS),
        .DATA_W  (SAMPLE_W)
    ) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .rxd       (rxd),
        .byte_valid(byte_valid),
        .byte_data (byte_data)
    );

    wp_bank_ctrl #(
        .COLS(COLS),
        .AW  (XW)
    ) u_banks (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_valid (byte_valid),
        .frame_start(frame_start),
        .we         (ram_we),
        .wr_addr    (wr_addr),
        .wr_bank    (wr_bank),
        .rd_bank    (rd_bank),
        .full       (buf_full),
        .disp_valid (disp_valid)
    );

    wp_sample_ram #(
        .AW(XW),
        .DW(SAMPLE_W)
    ) u_ram (
        .clk  (clk),
        .we   (ram_we),
        .waddr({wr_bank, wr_addr}),
        .wdata(byte_data),
        .raddr({rd_bank, pix_x}),
        .rdata(sample)
    );

    always_comb begin
        p_d          = p_q;
        p_d.y        = pix_y;
        p_d.in_range = (pix_x <= XW'(COLS - 1));
        p_d.valid    = disp_valid;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_q <= '0;
        end else begin
            p_q <= p_d;
        end
    end

    always_comb begin
        pix_on = 1'b0;
        if (p_q.valid && p_q.in_range && (int'(sample) <= ROWS - 1)) begin
            pix_on = (int'(p_q.y) == (ROWS - 1 - int'(sample)));
        end
    end
endmodule

// File: rtl/wp_plotter_checker.sv
module wp_plotter_checker #(
    parameter int COLS = 320,
    parameter int AW   = 9
) (
    input logic          clk,
    input logic          rst_n,
    input logic          frame_start,
    input logic          pix_on,
    input logic          byte_valid,
    input logic          we,
    input logic          full,
    input logic          wr_bank,
    input logic [AW-1:0] wr_addr,
    input logic          disp_valid
);
    a_r1_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |=> !byte_valid);

    a_r4_full_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (we && wr_addr == AW'(COLS - 1)) |=> full);

    a_r5_no_write_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !we);

    a_r6_hold_when_incomplete: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && !full) |=> $stable(wr_bank));

    a_r10_swap_only_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(wr_bank));

    a_r7_dark_before_swap: assert property (@(posedge clk) disable iff (!rst_n)
        !disp_valid |-> !pix_on);

    always_ff @(posedge clk) begin
        if (rst_n) begin
            a_r4_addr_in_range: assert (wr_addr <= AW'(COLS - 1));
        end
    end
endmodule

bind wave_plotter wp_plotter_checker #(
    .COLS(COLS),
    .AW  (XW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_start(frame_start),
    .pix_on     (pix_on),
    .byte_valid (byte_valid),
    .we         (ram_we),
    .full       (buf_full),
    .wr_bank    (wr_bank),
    .wr_addr    (wr_addr),
    .disp_valid (disp_valid)
);

// File: tb/wave_plotter_test.sv
module wave_plotter_test;
    localparam int COLS  = 6;
    localparam int ROWS  = 16;
    localparam int TDIV  = 2;
    localparam int OVS   = 16;
    localparam int BITC  = TDIV * OVS;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rxd = 1'b1;
    logic       frame_start = 1'b0;
    logic [2:0] pix_x = '0;
    logic [3:0] pix_y = '0;
    logic       pix_on;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    int  wbuf  [COLS];
    int  shown [COLS];
    int  wcnt  = 0;
    bit  mfull = 1'b0;
    bit  mvalid = 1'b0;

    always #2.5 clk = ~clk;

    wave_plotter #(
        .COLS(COLS), .ROWS(ROWS), .TICK_DIV(TDIV), .OVS(OVS), .SAMPLE_W(8)
    ) uut (
        .clk(clk), .rst_n(rst_n), .rxd(rxd), .frame_start(frame_start),
        .pix_x(pix_x), .pix_y(pix_y), .pix_on(pix_on)
    );

    task automatic check(input string req, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // R1 R3: one serial frame; model updated from the requirements
    task automatic send_byte(input logic [7:0] b, input bit stop_ok);
        @(negedge clk) rxd = 1'b0;
        repeat (BITC) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd = b[i];
            repeat (BITC) @(negedge clk);
        end
        rxd = stop_ok;
        repeat (BITC) @(negedge clk);
        rxd = 1'b1;
        repeat (2 * BITC) @(negedge clk);
        if (stop_ok && !mfull) begin
            wbuf[wcnt] = int'(b);
            if (wcnt == COLS - 1) begin
                wcnt  = 0;
                mfull = 1'b1;
            end else begin
                wcnt++;
            end
        end
    endtask

    // R2: low pulse shorter than half a bit
    task automatic glitch();
        @(negedge clk) rxd = 1'b0;
        repeat (4) @(negedge clk);
        rxd = 1'b1;
        repeat (2 * BITC) @(negedge clk);
    endtask

    task automatic strobe();
        @(negedge clk) frame_start = 1'b1;
        @(negedge clk) frame_start = 1'b0;
        if (mfull) begin
            for (int i = 0; i < COLS; i++) shown[i] = wbuf[i];
            mfull  = 1'b0;
            wcnt   = 0;
            mvalid = 1'b1;
        end
        repeat (2) @(negedge clk);
    endtask

    // R7 R8 R9: every coordinate, expected row computed arithmetically
    task automatic sweep(input string tag);
        for (int x = 0; x < 8; x++) begin
            for (int y = 0; y < ROWS; y++) begin
                int    exp;
                string req;
                @(negedge clk);
                pix_x = 3'(x);
                pix_y = 4'(y);
                @(negedge clk);
                exp = 0;
                if (!mvalid) req = "R7";
                else if (x >= COLS) req = "R9";
                else begin
                    req = "R8";
                    if (shown[x] <= ROWS - 1 && y == ROWS - 1 - shown[x]) exp = 1;
                end
                check(req, int'(pix_on), exp,
                      $sformatf("%s x=%0d y=%0d", tag, x, y));
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R7", int'(pix_on), 0, "reset state");

        // partial fill, glitch and broken stop bit, strobe without swap
        send_byte(8'd15, 1'b1);
        send_byte(8'd0, 1'b1);
        glitch();                  // R2
        send_byte(8'h55, 1'b0);    // R3
        send_byte(8'd7, 1'b1);
        send_byte(8'd3, 1'b1);
        strobe();                  // R6: incomplete
        sweep("R6 incomplete first fill");

        // complete the buffer; surplus byte must be dropped (R5)
        send_byte(8'd200, 1'b1);
        send_byte(8'd16, 1'b1);
        send_byte(8'd3, 1'b1);     // R5
        strobe();
        sweep("R4 first trace");

        // R10: filling runs while the frame is swept
        fork
            begin
                send_byte(8'd0, 1'b1);
                send_byte(8'd14, 1'b1);
                send_byte(8'd255, 1'b1);
            end
            sweep("R10 during fill");
        join
        strobe();                  // R6: incomplete, trace unchanged
        sweep("R6 hold trace");

        glitch();
        send_byte(8'd9, 1'b1);
        send_byte(8'd1, 1'b1);
        send_byte(8'd12, 1'b1);
        strobe();
        sweep("R1 second trace");

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule